// File: doc/BRIEF.md
# Operand swizzle context applier

This block decides, for each vector-prefixed instruction, which of up to three source operands are swizzled and which 12-bit swizzle pattern each operand receives. It keeps seven context slots. Each slot holds a 24-bit swizzle context, a 3-bit operand mask and a schedule shift register. The schedule says, one bit per upcoming vector-prefixed instruction, whether that slot applies.

A load writes one slot's context and mask and appends a short schedule to that slot's queue. On every valid vector-prefixed instruction, the slots whose schedule head bit is set are merged by OR. The merged context is then split into two patterns, and these are handed out in order to the operands whose mask bits are set. After that, every schedule shifts by one position. Instructions without the vector prefix leave all schedule state alone and see no swizzle.

Top module: `swz_ctx_apply`

## Requirements
- R1: After reset every schedule queue is empty, so a vector-prefixed instruction sees all enables low, all patterns zero and the overflow flag low.
- R2: A load with `ld_slot_i` in 1..7 replaces that slot's context and mask. It also appends schedule bits from the 17-bit `ld_sched_i`: the highest set bit is a terminator and is not applied, and the bits below it are queued lowest bit first, after any bits already queued. A load with `ld_slot_i` = 0 changes nothing.
- R3: Each valid vector-prefixed instruction (`insn_valid_i` and `insn_vec_i` both high) consumes one schedule position in every slot independently.
- R4: When there is no valid vector-prefixed instruction, the outputs are all zero and no schedule position is consumed.
- R5: A slot is active when its schedule head bit is 1. The contexts of all active slots are merged by OR, and so are their masks.
- R6: The first pattern is merged context bits [11:0] and the second is bits [23:12]. Mask bit 0 selects source 1 (`src_en_o[0]`, `src_swz_o[11:0]`), bit 1 selects source 2 (`src_en_o[1]`, `src_swz_o[23:12]`) and bit 2 selects source 3 (`src_en_o[2]`, `src_swz_o[35:24]`).
- R7: The first pattern goes to the lowest-numbered selected source and the second pattern goes to the next selected source.
- R8: With all three mask bits set, source 3 is not swizzled (enable low, pattern zero) and `extra_req_o` is high.
- R9: With a zero merged mask, or with no active slot, all enables are low and all patterns are zero.
- R10: A slot queue holds at most 40 positions. Schedule bits that would go beyond that are dropped.
- R11: When a load and a vector-prefixed instruction arrive in the same cycle, the instruction uses the old queue head, and the new bits are appended after the remaining old bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Load strobe |
| ld_slot_i | input | 3 | Target slot, 1..7; 0 means no slot |
| ld_ctx_i | input | 24 | Swizzle context: second pattern in [23:12], first in [11:0] |
| ld_mask_i | input | 3 | Operand mask for the slot |
| ld_sched_i | input | 17 | Schedule bits with a terminator at the highest set bit |
| insn_valid_i | input | 1 | An instruction issues this cycle |
| insn_vec_i | input | 1 | The issuing instruction is vector-prefixed |
| src_en_o | output | 3 | Per-source swizzle enable |
| src_swz_o | output | 36 | Per-source pattern, source 1 in the low 12 bits |
| extra_req_o | output | 1 | A third pattern was requested |

## Verification
The bench targets ordering and timing corners.

- **Source 1 and source 3 selected.** The second pattern must land on source 3. A design with fixed per-operand patterns would send it to source 2.
- **All three mask bits set.** Source 3 must stay unswizzled and the flag must rise. A wrong design would give source 3 a pattern.
- **Mask and patterns from separate slots.** The merge must combine a mask-only slot with a pattern-only slot.
- **Non-vector instruction between vector ones.** This exposes any design that shifts on every instruction.
- **Load in the same cycle as a shift, a second load onto a busy slot, and a queue filled past 40.** These catch off-by-one errors in the append offset and a missing clamp, which show up as swizzles appearing one instruction early or late, or as a wrapped-around schedule.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int unsigned SWZ_W   = 12;
  localparam int unsigned CTX_W   = 2 * SWZ_W;
  localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/swz_slot.sv
module swz_slot #(
  parameter int unsigned SCHED_LEN = 40,
  parameter int unsigned LOAD_W    = 17,
  parameter int unsigned CTX_W     = 24,
  parameter int unsigned NUM_SRC   = 3,
  localparam int unsigned FILL_W   = $clog2(SCHED_LEN + 1),
  localparam int unsigned CNT_W    = $clog2(LOAD_W),
  localparam int unsigned WIDE_W   = SCHED_LEN + LOAD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               ld_en_i,
  input  logic [CTX_W-1:0]   ld_ctx_i,
  input  logic [NUM_SRC-1:0] ld_mask_i,
  input  logic [LOAD_W-1:0]  ld_sched_i,
  output logic               head_o,
  output logic [CTX_W-1:0]   ctx_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [SCHED_LEN-1:0] sreg_q, sreg_s, sreg_n;
  logic [FILL_W-1:0]    fill_q, fill_s, fill_n;
  logic [CTX_W-1:0]     ctx_q;
  logic [NUM_SRC-1:0]   mask_q;
  logic [CNT_W-1:0]     cnt;
  logic [LOAD_W-1:0]    keep;
  logic [WIDE_W-1:0]    wide;
  logic [FILL_W:0]      sum;

  always_comb begin
    fill_s = (step_i && fill_q != '0) ? fill_q - 1'b1 : fill_q;
    sreg_s = step_i ? (sreg_q >> 1) : sreg_q;
    cnt = '0;
    for (int i = 0; i < LOAD_W; i++)
      if (ld_sched_i[i]) cnt = CNT_W'(i);
    for (int i = 0; i < LOAD_W; i++)
      keep[i] = ld_sched_i[i] && (CNT_W'(i) < cnt);
    wide = WIDE_W'(keep) << fill_s;
    sum  = {1'b0, fill_s} + (FILL_W + 1)'(cnt);
    sreg_n = sreg_s;
    fill_n = fill_s;
    if (ld_en_i) begin
      sreg_n = sreg_s | wide[SCHED_LEN-1:0];
      fill_n = (sum > (FILL_W + 1)'(SCHED_LEN)) ? FILL_W'(SCHED_LEN) : sum[FILL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      fill_q <= '0;
      ctx_q  <= '0;
      mask_q <= '0;
    end else begin
      sreg_q <= sreg_n;
      fill_q <= fill_n;
      if (ld_en_i) begin
        ctx_q  <= ld_ctx_i;
        mask_q <= ld_mask_i;
      end
    end
  end

  assign head_o = sreg_q[0];
  assign ctx_o  = head_o ? ctx_q : '0;
  assign mask_o = head_o ? mask_q : '0;
endmodule

// File: rtl/swz_merge.sv
module swz_merge #(
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned CTX_W     = 24,
  parameter int unsigned NUM_SRC   = 3
) (
  input  logic [NUM_SLOTS-1:0][CTX_W-1:0]   ctx_i,
  input  logic [NUM_SLOTS-1:0][NUM_SRC-1:0] mask_i,
  output logic [CTX_W-1:0]                  ctx_o,
  output logic [NUM_SRC-1:0]                mask_o
);
  always_comb begin
    ctx_o  = '0;
    mask_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      ctx_o  = ctx_o | ctx_i[s];
      mask_o = mask_o | mask_i[s];
    end
  end
endmodule

// File: rtl/swz_route.sv
module swz_route #(
  parameter int unsigned SWZ_W   = 12,
  parameter int unsigned NUM_SRC = 3
) (
  input  logic                         act_i,
  input  logic [2*SWZ_W-1:0]           ctx_i,
  input  logic [NUM_SRC-1:0]           mask_i,
  output logic [NUM_SRC-1:0]           en_o,
  output logic [NUM_SRC-1:0][SWZ_W-1:0] swz_o,
  output logic                         extra_o
);
  int unsigned rank;

  always_comb begin
    rank    = 0;
    en_o    = '0;
    swz_o   = '0;
    extra_o = 1'b0;
    if (act_i) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (mask_i[i]) begin
          if (rank == 0) begin
            en_o[i]  = 1'b1;
            swz_o[i] = ctx_i[SWZ_W-1:0];
          end else if (rank == 1) begin
            en_o[i]  = 1'b1;
            swz_o[i] = ctx_i[2*SWZ_W-1:SWZ_W];
          end else begin
            extra_o = 1'b1;
          end
          rank = rank + 1;
        end
      end
    end
  end
endmodule

// File: rtl/swz_ctx_apply.sv
module swz_ctx_apply
  import swz_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned SCHED_LEN = 40,
  parameter int unsigned LOAD_W    = 17,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ld_valid_i,
  input  logic [SLOT_W-1:0]        ld_slot_i,
  input  logic [CTX_W-1:0]         ld_ctx_i,
  input  logic [NUM_SRC-1:0]       ld_mask_i,
  input  logic [LOAD_W-1:0]        ld_sched_i,
  input  logic                     insn_valid_i,
  input  logic                     insn_vec_i,
  output logic [NUM_SRC-1:0]       src_en_o,
  output logic [NUM_SRC*SWZ_W-1:0] src_swz_o,
  output logic                     extra_req_o
);
  logic                              step;
  logic [NUM_SLOTS-1:0]              slot_head;
  logic [NUM_SLOTS-1:0][CTX_W-1:0]   slot_ctx;
  logic [NUM_SLOTS-1:0][NUM_SRC-1:0] slot_mask;
  logic [CTX_W-1:0]                  merged_ctx;
  logic [NUM_SRC-1:0]                merged_mask;
  logic [NUM_SRC-1:0][SWZ_W-1:0]     route_swz;

  assign step = insn_valid_i && insn_vec_i;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic ld_hit;
    assign ld_hit = ld_valid_i && (ld_slot_i == SLOT_W'(s + 1));
    swz_slot #(
      .SCHED_LEN(SCHED_LEN), .LOAD_W(LOAD_W), .CTX_W(CTX_W), .NUM_SRC(NUM_SRC)
    ) u_slot (
      .clk_i, .rst_ni,
      .step_i(step), .ld_en_i(ld_hit),
      .ld_ctx_i, .ld_mask_i, .ld_sched_i,
      .head_o(slot_head[s]), .ctx_o(slot_ctx[s]), .mask_o(slot_mask[s])
    );
  end

  swz_merge #(.NUM_SLOTS(NUM_SLOTS), .CTX_W(CTX_W), .NUM_SRC(NUM_SRC)) u_merge (
    .ctx_i(slot_ctx), .mask_i(slot_mask), .ctx_o(merged_ctx), .mask_o(merged_mask)
  );

  swz_route #(.SWZ_W(SWZ_W), .NUM_SRC(NUM_SRC)) u_route (
    .act_i(step), .ctx_i(merged_ctx), .mask_i(merged_mask),
    .en_o(src_en_o), .swz_o(route_swz), .extra_o(extra_req_o)
  );

  assign src_swz_o = route_swz;
endmodule

// File: rtl/swz_ctx_apply_chk.sv
module swz_ctx_apply_chk #(
  parameter int unsigned NUM_SLOTS = 7,
  parameter int unsigned NUM_SRC   = 3,
  parameter int unsigned SWZ_W     = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     step,
  input logic                     ld_valid_i,
  input logic [NUM_SLOTS-1:0]     slot_head,
  input logic [NUM_SRC-1:0]       merged_mask,
  input logic [NUM_SRC-1:0]       src_en_o,
  input logic [NUM_SRC*SWZ_W-1:0] src_swz_o,
  input logic                     extra_req_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |-> (src_en_o == '0 && src_swz_o == '0 && !extra_req_o)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !ld_valid_i) |=> $stable(slot_head)); // R4
  AST_EN_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_o & ~merged_mask) == '0); // R5
  AST_TWO_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(src_en_o) <= 2); // R7
  AST_EXTRA_SRC3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extra_req_o |-> (src_en_o == 3'b011)); // R8
  AST_NO_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_head == '0) |-> (src_en_o == '0 && !extra_req_o)); // R9
endmodule

bind swz_ctx_apply swz_ctx_apply_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_SRC(swz_pkg::NUM_SRC), .SWZ_W(swz_pkg::SWZ_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step(step), .ld_valid_i(ld_valid_i),
  .slot_head(slot_head), .merged_mask(merged_mask), .src_en_o(src_en_o),
  .src_swz_o(src_swz_o), .extra_req_o(extra_req_o)
);

// File: tb/swz_ctx_apply_test.sv
module swz_ctx_apply_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_slot = '0;
  logic [23:0] ld_ctx = '0;
  logic [2:0]  ld_mask = '0;
  logic [16:0] ld_sched = '0;
  logic        insn_valid = 1'b0;
  logic        insn_vec = 1'b0;
  logic [2:0]  src_en;
  logic [35:0] src_swz;
  logic        extra_req;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  swz_ctx_apply uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_slot_i(ld_slot), .ld_ctx_i(ld_ctx),
    .ld_mask_i(ld_mask), .ld_sched_i(ld_sched),
    .insn_valid_i(insn_valid), .insn_vec_i(insn_vec),
    .src_en_o(src_en), .src_swz_o(src_swz), .extra_req_o(extra_req)
  );

  task automatic expect_out(string req, logic [2:0] en, logic [35:0] swz, logic ex);
    checks++;
    if (src_en !== en || src_swz !== swz || extra_req !== ex) begin
      fails++;
      $display("FAIL %s: got en=%b swz=%h extra=%b, expected en=%b swz=%h extra=%b",
               req, src_en, src_swz, extra_req, en, swz, ex);
    end
  endtask

  task automatic load(logic [2:0] slot, logic [23:0] ctx, logic [2:0] mask, logic [16:0] sched);
    @(negedge clk);
    ld_valid = 1'b1; ld_slot = slot; ld_ctx = ctx; ld_mask = mask; ld_sched = sched;
    @(posedge clk); #1;
    ld_valid = 1'b0;
  endtask

  // one instruction issue; outputs checked in the issue cycle
  task automatic issue(logic vec, string req, logic [2:0] en, logic [35:0] swz, logic ex);
    @(negedge clk);
    insn_valid = 1'b1; insn_vec = vec;
    #1 expect_out(req, en, swz, ex);
    @(posedge clk); #1;
    insn_valid = 1'b0; insn_vec = 1'b0;
  endtask

  task automatic t_reset();
    issue(1'b1, "R1", 3'b000, '0, 1'b0);
    load(3'd0, 24'hFFFFFF, 3'b111, 17'h00003);
    issue(1'b1, "R2 slot0", 3'b000, '0, 1'b0);
  endtask

  task automatic t_single();
    load(3'd1, 24'h456123, 3'b010, 17'b1101);
    issue(1'b1, "R6", 3'b010, {12'h0, 12'h123, 12'h0}, 1'b0);
    issue(1'b1, "R3", 3'b000, '0, 1'b0);
    issue(1'b1, "R2", 3'b010, {12'h0, 12'h123, 12'h0}, 1'b0);
    issue(1'b1, "R3 drained", 3'b000, '0, 1'b0);
  endtask

  task automatic t_nonvec_order();
    load(3'd2, 24'hBBBAAA, 3'b101, 17'b11);
    issue(1'b0, "R4", 3'b000, '0, 1'b0);
    issue(1'b1, "R7", 3'b101, {12'hBBB, 12'h0, 12'hAAA}, 1'b0);
    issue(1'b1, "R4 drained", 3'b000, '0, 1'b0);
  endtask

  task automatic t_merge();
    load(3'd3, 24'h000A5A, 3'b000, 17'b11);
    load(3'd4, 24'h3C3000, 3'b110, 17'b11);
    issue(1'b1, "R5", 3'b110, {12'h3C3, 12'hA5A, 12'h0}, 1'b0);
    issue(1'b1, "R5 drained", 3'b000, '0, 1'b0);
  endtask

  task automatic t_three();
    load(3'd5, 24'h222111, 3'b111, 17'b11);
    issue(1'b1, "R8", 3'b011, {12'h0, 12'h222, 12'h111}, 1'b1);
  endtask

  task automatic t_zero_mask();
    load(3'd6, 24'h999888, 3'b000, 17'b11);
    issue(1'b1, "R9", 3'b000, '0, 1'b0);
  endtask

  task automatic t_append();
    load(3'd5, 24'h000321, 3'b001, 17'b10);
    load(3'd5, 24'h000321, 3'b001, 17'b11);
    issue(1'b1, "R2 append", 3'b000, '0, 1'b0);
    issue(1'b1, "R2 append", 3'b001, {24'h0, 12'h321}, 1'b0);
    issue(1'b1, "R2 append", 3'b000, '0, 1'b0);
  endtask

  task automatic t_overlap();
    load(3'd6, 24'h000654, 3'b001, 17'b101);
    @(negedge clk);
    insn_valid = 1'b1; insn_vec = 1'b1;
    ld_valid = 1'b1; ld_slot = 3'd6; ld_ctx = 24'h000654; ld_mask = 3'b001; ld_sched = 17'b11;
    #1 expect_out("R11", 3'b001, {24'h0, 12'h654}, 1'b0);
    @(posedge clk); #1;
    insn_valid = 1'b0; insn_vec = 1'b0; ld_valid = 1'b0;
    issue(1'b1, "R11", 3'b000, '0, 1'b0);
    issue(1'b1, "R11", 3'b001, {24'h0, 12'h654}, 1'b0);
    issue(1'b1, "R11", 3'b000, '0, 1'b0);
  endtask

  task automatic t_capacity();
    load(3'd7, 24'h000777, 3'b001, 17'h10000);
    load(3'd7, 24'h000777, 3'b001, 17'h10000);
    load(3'd7, 24'h000777, 3'b001, 17'h1FFFF);
    for (int k = 1; k <= 41; k++) begin
      if (k > 32 && k <= 40) issue(1'b1, "R10", 3'b001, {24'h0, 12'h777}, 1'b0);
      else                   issue(1'b1, "R10", 3'b000, '0, 1'b0);
    end
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_nonvec_order();
        t_merge();
        t_three();
        t_zero_mask();
        t_append();
        t_overlap();
        t_capacity();
      end
      begin
        #(CLK_PERIOD * 5000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule